// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to an operational state. After reset it holds the command pins at NOP for a configurable number of clocks, which covers the mandatory power-up settling time. It then closes every bank with a precharge-all command and issues two auto-refresh commands. Finally it writes a configured operating-mode word into the device's mode register. Every gap between two commands is padded with NOPs and lasts a configured number of clocks.

When the sequence is complete, `init_done` rises and stays high until the next reset. After that point the block drives only NOPs, and the pins can be handed over to the normal access controller. A synchronous reset applied at any point restarts the whole sequence from the power-up wait. Clock enable is held high throughout. All pin outputs come from registers, so each pin changes one clock after the internal decision that drives it.

Top module: `sdram_bringup`

## Requirements
- R1: `sd_cke` is 1 in the reset state and at every clock edge after it.
- R2: Commands are encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`}, and NOP is 0111. After reset is released, only NOP is driven until the precharge command appears, which happens at clock edge `POWERUP_CYC`+1.
- R3: The precharge command is 0010 and is driven with `sd_addr[10]` = 1, which closes all banks.
- R4: The first refresh (0001) appears exactly `TRP_CYC` edges after the precharge.
- R5: The second refresh (0001) appears exactly `TRFC_CYC` edges after the first refresh.
- R6: The mode load (0000) appears exactly `TRFC_CYC` edges after the second refresh. During the mode load, `sd_addr[11:0]` = `MODE_VAL`, `sd_addr` bits 12 and above are 0, and `sd_ba` = 0.
- R7: `init_done` rises exactly `TMRD_CYC` edges after the mode load. Once high, it stays high, and the pins carry only NOP.
- R8: Every clock between two commands carries NOP.
- R9: A synchronous reset that is sampled at any point in the sequence returns the pins to NOP and `init_done` to 0 on that edge. After the reset is released, the full sequence repeats with the same timing.
- R10: In the reset state the pins carry NOP, `init_done` = 0, and `sd_addr` and `sd_ba` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins |
| sd_ba | output | BANK_W | Bank select pins |
| init_done | output | 1 | High once the sequence is complete |

## Verification
If the sequencer state is wrong, the pins show either a command at the wrong edge or a command that is skipped. The error therefore appears as a shifted command index or a missing refresh, no later than the first command after the fault. A wrong gap count moves every later command by the same amount, so each interval is compared exactly. A wrong address or mode selection shows up only during the precharge and mode-load cycles, and those cycles are checked field by field. Random reset points check that no stale count survives a reset, because a leftover count would shift the precharge of the next run.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;
  // Command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_PRE,
    ST_GAP_PRE,
    ST_REF1,
    ST_GAP_REF1,
    ST_REF2,
    ST_GAP_REF2,
    ST_LMR,
    ST_GAP_LMR,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sbu_gap_timer.sv
module sbu_gap_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= CNT_W'(RST_VAL);
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sbu_cmd_drive.sv
module sbu_cmd_drive
  import sdram_bringup_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sdr_cmd_e          cmd,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              done_in,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
      sd_addr   <= '0;
      sd_ba     <= '0;
      init_done <= 1'b0;
      sd_cke    <= 1'b1;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= cmd;
      sd_addr   <= addr_in;
      sd_ba     <= '0;
      init_done <= done_in;
      sd_cke    <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_bringup.sv
module sdram_bringup
  import sdram_bringup_pkg::*;
#(
  parameter int          ADDR_W      = 13,
  parameter int          BANK_W      = 2,
  parameter int          POWERUP_CYC = 5000,
  parameter int          TRP_CYC     = 2,
  parameter int          TRFC_CYC    = 4,
  parameter int          TMRD_CYC    = 2,
  parameter logic [11:0] MODE_VAL    = 12'h032
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_done
);
  // Gaps shorter than two clocks are raised to two.
  localparam int TRP_E  = (TRP_CYC  < 2) ? 2 : TRP_CYC;
  localparam int TRFC_E = (TRFC_CYC < 2) ? 2 : TRFC_CYC;
  localparam int TMRD_E = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int PUP_E  = (POWERUP_CYC < 1) ? 1 : POWERUP_CYC;
  localparam int MAX_A  = (PUP_E > TRP_E) ? PUP_E : TRP_E;
  localparam int MAX_B  = (TRFC_E > TMRD_E) ? TRFC_E : TMRD_E;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int PRE_BIT = 10;

  seq_state_e        st_q, st_d;
  sdr_cmd_e          cmd_c;
  logic [ADDR_W-1:0] addr_c;
  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_WAIT;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d   = st_q;
    cmd_c  = CMD_NOP;
    addr_c = '0;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_WAIT:     if (t_zero) st_d = ST_PRE;
      ST_PRE: begin
        cmd_c          = CMD_PRE;
        addr_c[PRE_BIT] = 1'b1;
        t_load         = 1'b1;
        t_val          = CNT_W'(TRP_E - 2);
        st_d           = ST_GAP_PRE;
      end
      ST_GAP_PRE:  if (t_zero) st_d = ST_REF1;
      ST_REF1: begin
        cmd_c  = CMD_REF;
        t_load = 1'b1;
        t_val  = CNT_W'(TRFC_E - 2);
        st_d   = ST_GAP_REF1;
      end
      ST_GAP_REF1: if (t_zero) st_d = ST_REF2;
      ST_REF2: begin
        cmd_c  = CMD_REF;
        t_load = 1'b1;
        t_val  = CNT_W'(TRFC_E - 2);
        st_d   = ST_GAP_REF2;
      end
      ST_GAP_REF2: if (t_zero) st_d = ST_LMR;
      ST_LMR: begin
        cmd_c       = CMD_LMR;
        addr_c[11:0] = MODE_VAL;
        t_load      = 1'b1;
        t_val       = CNT_W'(TMRD_E - 2);
        st_d        = ST_GAP_LMR;
      end
      ST_GAP_LMR:  if (t_zero) st_d = ST_DONE;
      ST_DONE:     st_d = ST_DONE;
      default:     st_d = ST_WAIT;
    endcase
  end

  sbu_gap_timer #(.CNT_W(CNT_W), .RST_VAL(PUP_E - 1)) timer_i (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  sbu_cmd_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) drive_i (
    .clk(clk), .rst(rst), .cmd(cmd_c), .addr_in(addr_c),
    .done_in(st_q == ST_DONE),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .sd_ba(sd_ba), .init_done(init_done)
  );
endmodule

// File: rtl/sdram_bringup_chk.sv
module sdram_bringup_chk
  import sdram_bringup_pkg::*;
#(
  parameter int          ADDR_W      = 13,
  parameter int          BANK_W      = 2,
  parameter int          POWERUP_CYC = 5000,
  parameter int          TRP_CYC     = 2,
  parameter int          TRFC_CYC    = 4,
  parameter int          TMRD_CYC    = 2,
  parameter logic [11:0] MODE_VAL    = 12'h032
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BANK_W-1:0] sd_ba,
  input logic              init_done
);
  logic [3:0]  pin_cmd;
  logic [3:0]  last_cmd;
  logic [15:0] since;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd <= CMD_NOP;
      since    <= '0;
    end else if (pin_cmd != CMD_NOP) begin
      last_cmd <= pin_cmd;
      since    <= 16'd1;
    end else if (since != 16'hFFFF) begin
      since <= since + 16'd1;
    end
  end

  assert_cke_high_R1: assert property (@(posedge clk) disable iff (rst) sd_cke);
  assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd == CMD_PRE) |-> sd_addr[10]);
  assert_pre_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd != CMD_NOP && last_cmd == CMD_PRE) |-> (int'(since) >= TRP_CYC));
  assert_ref_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd != CMD_NOP && last_cmd == CMD_REF) |-> (int'(since) >= TRFC_CYC));
  assert_mode_word_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd == CMD_LMR) |-> (sd_addr[11:0] == MODE_VAL && sd_addr[ADDR_W-1:12] == '0 && sd_ba == '0));
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (pin_cmd == CMD_NOP));
  assert_done_after_mode_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (last_cmd == CMD_LMR && int'(since) >= TMRD_CYC));
endmodule

bind sdram_bringup sdram_bringup_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .POWERUP_CYC(POWERUP_CYC),
  .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC), .MODE_VAL(MODE_VAL)
) chk_i (
  .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
  .init_done(init_done)
);

// File: tb/sdram_bringup_tb_top.sv
module sdram_bringup_tb_top;
  localparam int          ADDR_W = 13;
  localparam int          BANK_W = 2;
  localparam int          PUP    = 40;
  localparam int          TRP    = 3;
  localparam int          TRFC   = 5;
  localparam int          TMRD   = 2;
  localparam logic [11:0] MODE   = 12'h0A3;

  localparam int E_PRE  = PUP + 1;
  localparam int E_REF1 = E_PRE + TRP;
  localparam int E_REF2 = E_REF1 + TRFC;
  localparam int E_LMR  = E_REF2 + TRFC;
  localparam int E_DONE = E_LMR + TMRD;
  localparam int TOTAL  = E_DONE + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [ADDR_W-1:0] sd_addr;
  logic [BANK_W-1:0] sd_ba;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_bringup #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .POWERUP_CYC(PUP), .TRP_CYC(TRP),
    .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .MODE_VAL(MODE)
  ) dut_i (
    .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .init_done(init_done)
  );

  function automatic logic [3:0] exp_cmd(int k);
    if (k == E_PRE) return 4'b0010;
    if (k == E_REF1 || k == E_REF2) return 4'b0001;
    if (k == E_LMR) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic string tag_of(int k);
    if (k < E_PRE) return "R2";
    if (k == E_PRE) return "R3";
    if (k == E_REF1) return "R4";
    if (k == E_REF2) return "R5";
    if (k == E_LMR) return "R6";
    if (k >= E_DONE) return "R7";
    return "R8";
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_reset_state(string req);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, req, "reset cmd",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(init_done == 1'b0, req, "reset done", init_done, 0);
    chk(sd_cke == 1'b1, "R1", "reset cke", sd_cke, 1);
    chk(sd_addr == '0 && sd_ba == '0, "R10", "reset addr/ba", sd_addr, 0);
  endtask

  // Runs one sequence; abort_at > 0 applies reset at that edge.
  task automatic run_seq(int abort_at);
    rst = 1'b0;
    for (int k = 1; k <= TOTAL; k++) begin
      @(negedge clk);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == exp_cmd(k), tag_of(k), "cmd",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, exp_cmd(k));
      chk(sd_cke == 1'b1, "R1", "cke", sd_cke, 1);
      chk(init_done == (k >= E_DONE), "R7", "done", init_done, (k >= E_DONE));
      if (k == E_PRE) chk(sd_addr[10] == 1'b1, "R3", "a10", sd_addr[10], 1);
      if (k == E_LMR) begin
        chk(sd_addr == {1'b0, MODE}, "R6", "mode addr", sd_addr, {1'b0, MODE});
        chk(sd_ba == '0, "R6", "mode bank", sd_ba, 0);
      end
      if (k == abort_at) begin
        rst = 1'b1;
        @(negedge clk);
        chk_reset_state("R9");
        return;
      end
    end
    rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk_reset_state("R10");
    run_seq(0);
    run_seq(1);
    run_seq(E_LMR);
    run_seq(E_DONE + 2);
    for (int i = 0; i < 5; i++) begin
      int a;
      a = 1 + int'($urandom % TOTAL);
      run_seq(a);
    end
    run_seq(0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule